// File: doc/BRIEF.md
# Conditional Instruction Phase Controller

This controller schedules the activation of three datapath units for every instruction: a program-counter stepper (PC unit), an instruction fetcher (IF unit) and an arithmetic unit (ALU). Each instruction class has its own partial order of unit activations. Some classes activate a unit twice. The second activation of a unit has its own go output, named with a `2` suffix. Units that have no ordering between them form one stage and receive their go pulses in the same cycle. The next stage starts once every unit of the current stage has reported done.

The three conditional classes read a less-than flag at run time. When the flag is false, the fetch stage and the second arithmetic step are dropped from the schedule. The flag is captured when the first stage completes, and that value is kept for the rest of the instruction. A surrounding sequencer pulses `start` with the class, answers each go pulse with a one-cycle done pulse on that unit's line, and waits for `instr_done`.

The state machine has three states. `ST_IDLE` waits for `start`. `ST_RUN` waits for the dones of the current stage. `ST_CPL` drives the one-cycle completion strobe. The transitions are:
- **accept**: `ST_IDLE` to `ST_RUN` on `start`, which launches stage 0.
- **advance**: `ST_RUN` to `ST_RUN` when the stage clears and is not the last one, which launches the next stage.
- **finish**: `ST_RUN` to `ST_CPL` when the last stage clears.
- **retire**: `ST_CPL` to `ST_IDLE` unconditionally.

Top module: `phase_ctrl`

## Requirements
- R1: While `rst_n` is low and afterwards with no `start`, every go output and `instr_done` stay low.
- R2: Classes 0 (register ALU), 2 (register jump), 3 (immediate jump) and 4 (memory) run the stages PC, IF, ALU, IF2, one unit per stage.
- R3: Class 1 (immediate ALU) runs the stages PC, IF, {ALU, PC2}, IF2.
- R4: Classes 5, 6 and 7 (conditional) with `lt` high run the stages {ALU, PC}, IF, {ALU2, PC2}, IF2.
- R5: Classes 5, 6 and 7 with `lt` low run the stages {ALU, PC}, PC2, IF2. IF and ALU2 are never pulsed.
- R6: `lt` is sampled in the cycle in which stage 0 completes. Changes to `lt` after that cycle do not alter the remaining stages.
- R7: Every go pulse is exactly one cycle wide. All units of a stage are pulsed in the same cycle. A stage's pulses appear in the cycle after the `start` or the final done that caused them.
- R8: A stage advances only after a done has been seen from each of its units, in any order and in any cycles. A done from a unit that is not part of the current stage is ignored.
- R9: `instr_done` is high for exactly one cycle, in the cycle after the last stage's final done. No go pulse accompanies it.
- R10: A `start` in any cycle other than an idle one, including the `instr_done` cycle, produces no go pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an instruction (accepted only when idle) |
| iclass | input | 3 | Instruction class, 0..7 as listed in the requirements |
| lt | input | 1 | Less-than condition flag |
| done_pc | input | 1 | PC unit finished its activation |
| done_if | input | 1 | IF unit finished its activation |
| done_alu | input | 1 | ALU finished its activation |
| go_pc | output | 1 | First PC unit activation |
| go_if | output | 1 | First IF unit activation |
| go_alu | output | 1 | First ALU activation |
| go_pc2 | output | 1 | Second PC unit activation |
| go_if2 | output | 1 | Second IF unit activation |
| go_alu2 | output | 1 | Second ALU activation |
| instr_done | output | 1 | One-cycle instruction-complete strobe |

## Verification
The bench sweeps all eight classes, with the flag high and low, and with the dones of each concurrent pair delivered together or staggered. It predicts every stage mask from the class table.

Staggered dones catch a controller that advances on the first done instead of the last. Stray dones from units outside the stage catch one that counts any done. Flipping `lt` after stage 0 exposes a design that reads the flag live and so swaps the remaining stages in mid-instruction.

Extra `start` pulses during a stage and during the completion cycle target a controller that restarts while busy, which would show up as unexpected go pulses.

// File: rtl/pcu_pkg.sv
`timescale 1ns/1ps
package pcu_pkg;

    // Number of datapath units (PC, IF, ALU); each may be activated twice.
    localparam int UNIT_N   = 3;
    localparam int STEP_W   = 2 * UNIT_N;
    localparam int STAGE_N  = 4;
    localparam int STAGE_W  = $clog2(STAGE_N);
    localparam int CLASS_W  = 3;

    // Bit positions inside a stage mask; the low half is the first activation,
    // the high half the second activation of the same unit.
    localparam int B_PC   = 0;
    localparam int B_IF   = 1;
    localparam int B_ALU  = 2;
    localparam int B_PC2  = B_PC  + UNIT_N;
    localparam int B_IF2  = B_IF  + UNIT_N;
    localparam int B_ALU2 = B_ALU + UNIT_N;

    typedef logic [STEP_W-1:0] step_t;

    typedef enum logic [CLASS_W-1:0] {
        CL_ALU_RR  = 3'd0,
        CL_ALU_IR  = 3'd1,
        CL_ALU_RPC = 3'd2,
        CL_ALU_IPC = 3'd3,
        CL_MEM     = 3'd4,
        CL_C_RR    = 3'd5,
        CL_C_IR    = 3'd6,
        CL_C_IPC   = 3'd7
    } iclass_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_CPL  = 2'd2
    } ctl_state_e;

    function automatic step_t bit_of(input int pos);
        return step_t'(1) << pos;
    endfunction

endpackage

// File: rtl/pcu_sched.sv
`timescale 1ns/1ps
module pcu_sched
    import pcu_pkg::*;
(
    input  iclass_e               cls,
    input  logic                  cond,
    input  logic [STAGE_W-1:0]    idx,
    output step_t                 mask,
    output logic                  last
);

    typedef enum logic [1:0] {
        FAM_PLAIN = 2'd0,
        FAM_IMM   = 2'd1,
        FAM_CTRUE = 2'd2,
        FAM_CFALS = 2'd3
    } family_e;

    family_e fam;

    always_comb begin
        unique case (cls)
            CL_ALU_IR:                 fam = FAM_IMM;
            CL_C_RR, CL_C_IR, CL_C_IPC: fam = cond ? FAM_CTRUE : FAM_CFALS;
            default:                   fam = FAM_PLAIN;
        endcase
    end

    always_comb begin
        mask = '0;
        last = 1'b0;
        unique case (fam)
            FAM_PLAIN: begin
                case (idx)
                    2'd0:    mask = bit_of(B_PC);
                    2'd1:    mask = bit_of(B_IF);
                    2'd2:    mask = bit_of(B_ALU);
                    default: begin mask = bit_of(B_IF2); last = 1'b1; end
                endcase
            end
            FAM_IMM: begin
                case (idx)
                    2'd0:    mask = bit_of(B_PC);
                    2'd1:    mask = bit_of(B_IF);
                    2'd2:    mask = bit_of(B_ALU) | bit_of(B_PC2);
                    default: begin mask = bit_of(B_IF2); last = 1'b1; end
                endcase
            end
            FAM_CTRUE: begin
                case (idx)
                    2'd0:    mask = bit_of(B_ALU) | bit_of(B_PC);
                    2'd1:    mask = bit_of(B_IF);
                    2'd2:    mask = bit_of(B_ALU2) | bit_of(B_PC2);
                    default: begin mask = bit_of(B_IF2); last = 1'b1; end
                endcase
            end
            FAM_CFALS: begin
                case (idx)
                    2'd0:    mask = bit_of(B_ALU) | bit_of(B_PC);
                    2'd1:    mask = bit_of(B_PC2);
                    default: begin mask = bit_of(B_IF2); last = 1'b1; end
                endcase
            end
            default: begin
                mask = '0;
                last = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/pcu_tracker.sv
`timescale 1ns/1ps
module pcu_tracker
    import pcu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  step_t             load_mask,
    input  logic [UNIT_N-1:0] done,
    output logic              all_clear
);

    logic [UNIT_N-1:0] need;
    logic [UNIT_N-1:0] pend;

    // Both activations of a unit answer on the same done line.
    assign need = load_mask[UNIT_N-1:0] | load_mask[STEP_W-1:UNIT_N];

    generate
        for (genvar u = 0; u < UNIT_N; u++) begin : g_unit
            logic pend_q;
            always_ff @(posedge clk) begin
                if (!rst_n)
                    pend_q <= 1'b0;
                else if (load)
                    pend_q <= need[u];
                else if (done[u])
                    pend_q <= 1'b0;
            end
            assign pend[u] = pend_q;
        end
    endgenerate

    assign all_clear = ((pend & ~done) == '0);

endmodule

// File: rtl/pcu_fsm.sv
`timescale 1ns/1ps
module pcu_fsm
    import pcu_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [CLASS_W-1:0]    cls_in,
    input  logic                  lt,
    input  logic                  all_clear,
    input  step_t                 sched_mask,
    input  logic                  sched_last,
    output iclass_e               sched_cls,
    output logic                  sched_cond,
    output logic [STAGE_W-1:0]    sched_idx,
    output logic                  launch,
    output step_t                 go,
    output logic                  cpl,
    output logic                  busy
);

    ctl_state_e            state_q, state_d;
    iclass_e               cls_q;
    logic                  cond_q;
    logic [STAGE_W-1:0]    stage_q;
    logic                  last_q;
    logic                  accept, stage_end;

    assign accept    = (state_q == ST_IDLE) && start;
    assign stage_end = (state_q == ST_RUN) && all_clear;
    assign launch    = accept || (stage_end && !last_q);
    assign busy      = (state_q != ST_IDLE);

    // Schedule lookup: stage 0 of the incoming class when idle,
    // otherwise the stage after the current one.
    assign sched_cls  = (state_q == ST_IDLE) ? iclass_e'(cls_in) : cls_q;
    assign sched_idx  = (state_q == ST_IDLE) ? '0 : stage_q + 1'b1;
    assign sched_cond = (stage_q == '0) ? lt : cond_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start)     state_d = ST_RUN;
            ST_RUN:  if (all_clear) state_d = last_q ? ST_CPL : ST_RUN;
            ST_CPL:                 state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    // State register and instruction context.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cls_q   <= CL_ALU_RR;
            cond_q  <= 1'b0;
            stage_q <= '0;
            last_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept)
                cls_q <= iclass_e'(cls_in);
            if (stage_end && (stage_q == '0))
                cond_q <= lt;
            if (launch) begin
                stage_q <= sched_idx;
                last_q  <= sched_last;
            end
        end
    end

    // Registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            go  <= '0;
            cpl <= 1'b0;
        end else begin
            go  <= launch ? sched_mask : '0;
            cpl <= stage_end && last_q;
        end
    end

endmodule

// File: rtl/phase_ctrl.sv
`timescale 1ns/1ps
module phase_ctrl
    import pcu_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [2:0]  iclass,
    input  logic        lt,
    input  logic        done_pc,
    input  logic        done_if,
    input  logic        done_alu,
    output logic        go_pc,
    output logic        go_if,
    output logic        go_alu,
    output logic        go_pc2,
    output logic        go_if2,
    output logic        go_alu2,
    output logic        instr_done
);

    iclass_e               sched_cls;
    logic                  sched_cond;
    logic [STAGE_W-1:0]    sched_idx;
    step_t                 sched_mask;
    logic                  sched_last;
    logic                  launch;
    logic                  all_clear;
    logic                  busy;
    step_t                 go;
    logic [UNIT_N-1:0]     done_vec;

    assign done_vec[B_PC]  = done_pc;
    assign done_vec[B_IF]  = done_if;
    assign done_vec[B_ALU] = done_alu;

    pcu_sched u_sched (
        .cls  (sched_cls),
        .cond (sched_cond),
        .idx  (sched_idx),
        .mask (sched_mask),
        .last (sched_last)
    );

    pcu_tracker u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (launch),
        .load_mask (sched_mask),
        .done      (done_vec),
        .all_clear (all_clear)
    );

    pcu_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .cls_in     (iclass),
        .lt         (lt),
        .all_clear  (all_clear),
        .sched_mask (sched_mask),
        .sched_last (sched_last),
        .sched_cls  (sched_cls),
        .sched_cond (sched_cond),
        .sched_idx  (sched_idx),
        .launch     (launch),
        .go         (go),
        .cpl        (instr_done),
        .busy       (busy)
    );

    assign go_pc   = go[B_PC];
    assign go_if   = go[B_IF];
    assign go_alu  = go[B_ALU];
    assign go_pc2  = go[B_PC2];
    assign go_if2  = go[B_IF2];
    assign go_alu2 = go[B_ALU2];

endmodule

// File: rtl/pcu_chk.sv
`timescale 1ns/1ps
module pcu_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic [5:0] go_vec,
    input logic [2:0] done_vec,
    input logic       instr_done,
    input logic       busy
);

    // R9: completion strobe lasts one cycle
    a_r9_cpl_single: assert property (@(posedge clk) disable iff (!rst_n)
        instr_done |=> !instr_done);

    // R9: no unit is launched alongside the completion strobe
    a_r9_cpl_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        instr_done |-> (go_vec == 6'd0));

    // R9: completion follows a done
    a_r9_cpl_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        instr_done |-> $past(|done_vec));

    // R7: every launch is caused by a start or a done in the previous cycle
    a_r7_go_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (|go_vec) |-> ($past(start) || $past(|done_vec)));

    // R7: a stage never launches more than two units
    a_r7_pair_limit: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(go_vec) <= 2);

    // R10: start while busy and without a done launches nothing
    a_r10_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !(|done_vec)) |=> (go_vec == 6'd0));

endmodule

bind phase_ctrl pcu_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .go_vec     ({go_alu2, go_if2, go_pc2, go_alu, go_if, go_pc}),
    .done_vec   ({done_alu, done_if, done_pc}),
    .instr_done (instr_done),
    .busy       (busy)
);

// File: tb/sim_phase_ctrl.sv
`timescale 1ns/1ps
module sim_phase_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [2:0] iclass = 3'd0;
    logic       lt = 1'b0;
    logic       done_pc = 1'b0, done_if = 1'b0, done_alu = 1'b0;
    logic       go_pc, go_if, go_alu, go_pc2, go_if2, go_alu2, instr_done;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;

    always #2.5 clk = ~clk;

    phase_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .iclass(iclass), .lt(lt),
        .done_pc(done_pc), .done_if(done_if), .done_alu(done_alu),
        .go_pc(go_pc), .go_if(go_if), .go_alu(go_alu),
        .go_pc2(go_pc2), .go_if2(go_if2), .go_alu2(go_alu2),
        .instr_done(instr_done)
    );

    // Mask layout: {alu2, if2, pc2, alu, if, pc}
    function automatic logic [5:0] go_now();
        return {go_alu2, go_if2, go_pc2, go_alu, go_if, go_pc};
    endfunction

    function automatic int exp_len(int cls, bit c);
        if (cls >= 5 && !c) return 3;
        return 4;
    endfunction

    function automatic logic [5:0] exp_step(int cls, bit c, int s);
        logic [5:0] t [4];
        if (cls >= 5 && c) begin
            t[0] = 6'b000101; t[1] = 6'b000010; t[2] = 6'b101000; t[3] = 6'b010000;
        end else if (cls >= 5) begin
            t[0] = 6'b000101; t[1] = 6'b001000; t[2] = 6'b010000; t[3] = 6'b000000;
        end else if (cls == 1) begin
            t[0] = 6'b000001; t[1] = 6'b000010; t[2] = 6'b001100; t[3] = 6'b010000;
        end else begin
            t[0] = 6'b000001; t[1] = 6'b000010; t[2] = 6'b000100; t[3] = 6'b010000;
        end
        return t[s];
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive_done(input logic [2:0] u);
        done_pc  = u[0];
        done_if  = u[1];
        done_alu = u[2];
    endtask

    task automatic run_instr(input int cls, input bit c, input bit stagger,
                             input bit flip, input bit poke);
        string tg;
        int    len;
        if (flip)            tg = "R6";
        else if (cls >= 5)   tg = c ? "R4" : "R5";
        else if (cls == 1)   tg = "R3";
        else                 tg = "R2";
        len = exp_len(cls, c);
        @(negedge clk);
        start = 1'b1; iclass = 3'(cls); lt = c;
        @(negedge clk);
        start = 1'b0;
        for (int s = 0; s < len; s++) begin
            logic [5:0] m;
            logic [2:0] u;
            m = exp_step(cls, c, s);
            u = m[2:0] | m[5:3];
            check(go_now() == m, tg, go_now(), m);
            @(negedge clk);
            check(go_now() == 6'd0, "R7", go_now(), 0);
            if (poke) begin
                start = 1'b1; iclass = 3'(7 - cls);
                @(negedge clk);
                start = 1'b0;
                check(go_now() == 6'd0 && !instr_done, "R10", go_now(), 0);
            end
            if (stagger && $countones(u) == 2) begin
                logic [2:0] hi;
                hi = u[2] ? 3'b100 : 3'b010;
                drive_done(hi | (~u & 3'b111));
                @(negedge clk);
                drive_done(3'b000);
                check(go_now() == 6'd0 && !instr_done, "R8", go_now(), 0);
                @(negedge clk);
                check(go_now() == 6'd0, "R8", go_now(), 0);
                drive_done(u & ~hi);
            end else begin
                drive_done(u);
            end
            @(negedge clk);
            drive_done(3'b000);
            if (s == 0 && flip) lt = !c;
        end
        check(instr_done == 1'b1 && go_now() == 6'd0, "R9", {instr_done, go_now()}, 7'h40);
        if (poke) start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(instr_done == 1'b0, "R9", instr_done, 0);
        check(go_now() == 6'd0, "R10", go_now(), 0);
        @(negedge clk);
        check(go_now() == 6'd0, "R10", go_now(), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check(go_now() == 6'd0 && !instr_done, "R1", {instr_done, go_now()}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(go_now() == 6'd0 && !instr_done, "R1", {instr_done, go_now()}, 0);
        for (int cls = 0; cls < 8; cls++)
            for (int c = 0; c < 2; c++)
                for (int st = 0; st < 2; st++)
                    run_instr(cls, c[0], st[0], st[0], c[0] ^ st[0]);
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule